// File: doc/BRIEF.md
# Power-Aware Reset Supervisor with Watchdog

This block drives the active-low system reset of a chip. The reset is held low until three prerequisites are all true together: the combined power-good of the supplies, a clock-present indication and, when enabled by parameter, a configuration-ready flag. Once all three are true, a programmable number of hold cycles must pass before the reset is released. Any reset assertion lasts at least a fixed minimum number of cycles. All inputs are synchronous to the free-running supervisor clock `clk`.

While the system runs, a watchdog expects periodic single-cycle kicks. If the kicks stop for too long, the block does not just pulse the reset. It raises a power-cycle request to the supply sequencer and keeps the reset low until the sequencer has taken power-good down. After that the normal release rules apply again, so power-good must come back and the hold time must pass.

The controller has four states. `ST_IDLE` means a prerequisite is missing. `ST_HOLD` means the prerequisites are met and the hold cycles are being counted. `ST_RUN` means reset is released and the watchdog is armed. `ST_PWRCYC` means a power cycle has been requested. The transitions are:
- IDLE→HOLD: the prerequisites become met.
- IDLE→RUN: the prerequisites are met, the hold time is zero and the minimum pulse is done.
- HOLD→IDLE: a prerequisite drops.
- HOLD→RUN: the hold count is reached and the minimum pulse is done.
- RUN→IDLE: a prerequisite drops.
- RUN→PWRCYC: the watchdog expires.
- PWRCYC→IDLE: power-good is sampled low.

Top module: `rst_supervisor`

## Requirements
- R1: While `arst_n` is low, and afterwards until the release rule of R2 is met, `sys_rst_n` is 0 and `pcycle_req` is 0.
- R2: Release needs `pwr_good`, `clk_present` and `cfg_ready` all high (with USE_CFG_READY=1). `sys_rst_n` rises at the clock edge at which all of them have been sampled high on `hold_cycles`+1 consecutive edges, provided R5 is also met.
- R3: While `sys_rst_n` is 1, a prerequisite sampled low at an edge makes `sys_rst_n` 0 after that edge.
- R4: A prerequisite sampled low while the hold count is running restarts the count from zero, so release again needs `hold_cycles`+1 consecutive good edges.
- R5: Every low period of `sys_rst_n` lasts at least MIN_PULSE clock cycles, even when `hold_cycles` is 0.
- R6: While `sys_rst_n` is 1, if `wdt_kick` is not sampled high for `wdt_timeout` consecutive edges (counted from the release edge or the last kick edge), then after the `wdt_timeout`-th edge `sys_rst_n` is 0 and `pcycle_req` is 1.
- R7: A `wdt_kick` pulse sampled high while `sys_rst_n` is 1 restarts the R6 window. Kicks spaced closer than `wdt_timeout` keep the reset released.
- R8: Kicks sampled while `sys_rst_n` is 0 have no effect. The watchdog window starts at the release edge.
- R9: `pcycle_req` stays 1 and `sys_rst_n` stays 0 until `pwr_good` is sampled low. `pcycle_req` is 0 after that edge, and release then follows R2.
- R10: If a prerequisite drop and a watchdog expiry fall on the same edge, the drop wins: `sys_rst_n` goes to 0 and `pcycle_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running supervisor clock |
| arst_n | input | 1 | Asynchronous active-low reset of the supervisor itself |
| pwr_good | input | 1 | Combined power-good of all required supplies |
| clk_present | input | 1 | System clock detected and stable |
| cfg_ready | input | 1 | Configuration available (used when USE_CFG_READY=1) |
| hold_cycles | input | HOLD_W | Number of hold cycles after the prerequisites are met |
| wdt_timeout | input | WDT_W | Watchdog window in cycles (1 or more) |
| wdt_kick | input | 1 | Single-cycle watchdog service pulse |
| sys_rst_n | output | 1 | Active-low system reset |
| pcycle_req | output | 1 | Power-cycle request to the supply sequencer |

## Verification
The embedded assertions check the following on every cycle:
- A missing prerequisite always yields reset on the next cycle.
- Release only happens with prerequisites good and the minimum pulse counted.
- A power-cycle request only starts from a running system with no prerequisite drop.
- The request holds until power-good is low.
- A kick blocks expiry on the next cycle.

Exact counts need the bench scenarios, together with a cycle model driven by random prerequisite drops, kicks and a mimicked sequencer. These counts are:
- the hold count and its restart after a glitch;
- the precise minimum pulse width with zero hold;
- the exact watchdog window from release and from the last kick;
- that kicks during reset leave no trace.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Controller states of the reset supervisor
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // prerequisite missing, reset asserted
        ST_HOLD   = 2'd1,   // prerequisites met, counting hold cycles
        ST_RUN    = 2'd2,   // reset released, watchdog armed
        ST_PWRCYC = 2'd3    // watchdog expired, waiting for power to drop
    } rsv_state_e;

endpackage

// File: rtl/rsv_prereq.sv
module rsv_prereq #(
    parameter bit USE_CFG_READY = 1'b1
) (
    input  logic pwr_good,
    input  logic clk_present,
    input  logic cfg_ready,
    output logic all_ok
);

    generate
        if (USE_CFG_READY) begin : g_with_cfg
            assign all_ok = pwr_good & clk_present & cfg_ready;
        end else begin : g_no_cfg
            logic cfg_ignored;
            assign cfg_ignored = cfg_ready & 1'b0;
            assign all_ok = (pwr_good & clk_present) | cfg_ignored;
        end
    endgenerate

endmodule

// File: rtl/rsv_min_pulse.sv
module rsv_min_pulse #(
    parameter int MIN_PULSE = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clear,
    output logic done
);

    localparam int PW = $clog2(MIN_PULSE + 1);
    localparam logic [PW-1:0] PMAX = PW'(MIN_PULSE - 1);

    logic [PW-1:0] cnt_q;

    // Counts the cycles spent with reset asserted, saturating at PMAX
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != PMAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == PMAX);

    // R5: a fresh reset assertion cannot be complete on the following cycle
    a_r5_clear_blocks_done: assert property (@(posedge clk) disable iff (!arst_n)
        clear && (MIN_PULSE > 1) |=> !done);

endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
    parameter int WDT_W = 16
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             arm,
    input  logic             kick,
    input  logic [WDT_W-1:0] limit,
    output logic             expire
);

    localparam logic [WDT_W:0] WONE = 1;

    logic [WDT_W-1:0] cnt_q;
    logic [WDT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + WONE;
    assign expire  = arm & ~kick & (cnt_inc >= {1'b0, limit});

    // Idle cycles since arming or the last kick; cleared while disarmed
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (!arm || kick) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_inc[WDT_W-1:0];
        end
    end

    // R7: a kick gives at least one further cycle before expiry
    a_r7_kick_restarts: assert property (@(posedge clk) disable iff (!arst_n)
        arm && kick && (limit > 1) |=> !expire);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int HOLD_W        = 16,
    parameter int WDT_W         = 16,
    parameter int MIN_PULSE     = 8,
    parameter bit USE_CFG_READY = 1'b1
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              pwr_good,
    input  logic              clk_present,
    input  logic              cfg_ready,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [WDT_W-1:0]  wdt_timeout,
    input  logic              wdt_kick,
    output logic              sys_rst_n,
    output logic              pcycle_req
);

    import rsv_pkg::*;

    localparam logic [HOLD_W-1:0] HOLD_ONE = 1;

    rsv_state_e        state_q, state_d;
    logic [HOLD_W-1:0] hold_q, hold_d;
    logic              prq_ok;
    logic              pulse_done;
    logic              wdt_expire;
    logic              in_run;

    assign in_run = (state_q == ST_RUN);

    rsv_prereq #(
        .USE_CFG_READY (USE_CFG_READY)
    ) u_prereq (
        .pwr_good    (pwr_good),
        .clk_present (clk_present),
        .cfg_ready   (cfg_ready),
        .all_ok      (prq_ok)
    );

    rsv_min_pulse #(
        .MIN_PULSE (MIN_PULSE)
    ) u_min_pulse (
        .clk    (clk),
        .arst_n (arst_n),
        .clear  (in_run),
        .done   (pulse_done)
    );

    rsv_watchdog #(
        .WDT_W (WDT_W)
    ) u_wdt (
        .clk    (clk),
        .arst_n (arst_n),
        .arm    (in_run),
        .kick   (wdt_kick),
        .limit  (wdt_timeout),
        .expire (wdt_expire)
    );

    // Next-state and hold-count logic
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            ST_IDLE: begin
                hold_d = '0;
                if (prq_ok) begin
                    if ((hold_cycles == '0) && pulse_done) begin
                        state_d = ST_RUN;
                    end else begin
                        state_d = ST_HOLD;
                        hold_d  = HOLD_ONE;
                    end
                end
            end
            ST_HOLD: begin
                if (!prq_ok) begin
                    state_d = ST_IDLE;
                    hold_d  = '0;
                end else if ((hold_q >= hold_cycles) && pulse_done) begin
                    state_d = ST_RUN;
                    hold_d  = '0;
                end else if (hold_q < hold_cycles) begin
                    hold_d = hold_q + HOLD_ONE;
                end
            end
            ST_RUN: begin
                hold_d = '0;
                if (!prq_ok) begin
                    state_d = ST_IDLE;
                end else if (wdt_expire) begin
                    state_d = ST_PWRCYC;
                end
            end
            ST_PWRCYC: begin
                hold_d = '0;
                if (!pwr_good) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                hold_d  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        sys_rst_n  = 1'b0;
        pcycle_req = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_HOLD:   ;
            ST_RUN:    sys_rst_n  = 1'b1;
            ST_PWRCYC: pcycle_req = 1'b1;
            default:   ;
        endcase
    end

    // R3: a missing prerequisite forces reset on the next cycle
    a_r3_drop_forces_reset: assert property (@(posedge clk) disable iff (!arst_n)
        !prq_ok |=> !sys_rst_n);

    // R2: release only with all prerequisites sampled good
    a_r2_release_needs_ok: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst_n) |-> $past(prq_ok));

    // R5: release only once the minimum pulse is complete
    a_r5_min_pulse: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst_n) |-> $past(pulse_done));

    // R6: a power-cycle request comes only from a running system on expiry
    a_r6_req_from_run: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(pcycle_req) |-> $past(sys_rst_n) && $past(wdt_expire));

    // R10: a prerequisite drop on the same edge prevents the request
    a_r10_drop_beats_expiry: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(pcycle_req) |-> $past(prq_ok));

    // R9: the request persists while power stays good
    a_r9_req_holds: assert property (@(posedge clk) disable iff (!arst_n)
        pcycle_req && pwr_good |=> pcycle_req);

    // R9: reset stays low throughout the request
    a_r9_req_keeps_reset: assert property (@(posedge clk) disable iff (!arst_n)
        pcycle_req |-> !sys_rst_n);

endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;

    localparam int MINP  = 4;
    localparam int HOLDV = 5;
    localparam int TOUT  = 20;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        pwr_good = 1'b0;
    logic        clk_present = 1'b0;
    logic        cfg_ready = 1'b0;
    logic [15:0] hold_cycles = 16'(HOLDV);
    logic [15:0] wdt_timeout = 16'(TOUT);
    logic        kick_man = 1'b0;
    logic        kick_auto = 1'b0;
    logic        auto_en = 1'b0;
    logic [7:0]  kcnt = '0;
    logic        wdt_kick;
    logic        sys_rst_n;
    logic        pcycle_req;

    int nchk = 0;
    int nerr = 0;

    assign wdt_kick = kick_man | kick_auto;

    always #4 clk = ~clk;

    rst_supervisor #(
        .HOLD_W        (16),
        .WDT_W         (16),
        .MIN_PULSE     (MINP),
        .USE_CFG_READY (1'b1)
    ) uut (
        .clk         (clk),
        .arst_n      (arst_n),
        .pwr_good    (pwr_good),
        .clk_present (clk_present),
        .cfg_ready   (cfg_ready),
        .hold_cycles (hold_cycles),
        .wdt_timeout (wdt_timeout),
        .wdt_kick    (wdt_kick),
        .sys_rst_n   (sys_rst_n),
        .pcycle_req  (pcycle_req)
    );

    // Background kicker, one pulse every eight cycles
    always @(negedge clk) begin
        kcnt      <= kcnt + 8'd1;
        kick_auto <= auto_en && (kcnt[2:0] == 3'd0);
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model built from the requirements
    bit m_rst_n = 1'b0;
    bit m_req   = 1'b0;
    int m_consec = 0;
    int m_low    = 0;
    int m_idle   = 0;

    function automatic bit exp_release(input int consec, input int low, input int hold);
        return (consec >= hold + 1) && (low >= MINP);
    endfunction

    function automatic bit exp_expiry(input int idle, input bit kick, input int tout);
        return !kick && (idle + 1 >= tout);
    endfunction

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            m_rst_n = 1'b0; m_req = 1'b0; m_consec = 0; m_low = 0; m_idle = 0;
        end else begin
            bit ok;
            ok = pwr_good && clk_present && cfg_ready;
            if (m_rst_n) begin
                if (!ok) begin
                    m_rst_n = 1'b0; m_low = 0; m_consec = 0;
                end else if (exp_expiry(m_idle, wdt_kick, int'(wdt_timeout))) begin
                    m_rst_n = 1'b0; m_req = 1'b1; m_low = 0; m_consec = 0;
                end else begin
                    m_idle = wdt_kick ? 0 : m_idle + 1;
                end
            end else if (m_req) begin
                m_low++;
                if (!pwr_good) m_req = 1'b0;
            end else begin
                m_low++;
                m_consec = ok ? m_consec + 1 : 0;
                if (ok && exp_release(m_consec, m_low, int'(hold_cycles))) begin
                    m_rst_n = 1'b1; m_idle = 0;
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (arst_n) begin
            chk("R3 cycle model reset", int'(sys_rst_n), int'(m_rst_n));
            chk("R6 cycle model request", int'(pcycle_req), int'(m_req));
        end
    end

    task automatic wait_release(output int n);
        n = 0;
        while (!sys_rst_n && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!pcycle_req && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R1 watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int n;
        int lowcnt;
        int seed;
        int dly;
        int cp_off;
        int quiet;
        seed = $urandom(32'd20240611);

        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1 rst during arst", int'(sys_rst_n), 0);
        chk("R1 req during arst", int'(pcycle_req), 0);
        arst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 rst after arst, no prereq", int'(sys_rst_n), 0);

        // R2 cfg_ready still missing
        pwr_good = 1'b1; clk_present = 1'b1; auto_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 held without cfg_ready", int'(sys_rst_n), 0);
        cfg_ready = 1'b1;
        wait_release(n);
        chk("R2 release after hold", n, HOLDV + 1);

        // R7 regular kicks keep running
        repeat (60) @(negedge clk);
        chk("R7 running with kicks", int'(sys_rst_n), 1);
        chk("R7 no request with kicks", int'(pcycle_req), 0);

        // R6 watchdog window from last kick
        auto_en = 1'b0;
        repeat (2) @(negedge clk);
        kick_man = 1'b1;
        @(negedge clk);
        kick_man = 1'b0;
        wait_req(n);
        chk("R6 expiry after window", n, TOUT);
        chk("R6 reset low on expiry", int'(sys_rst_n), 0);

        // R9 request persists, kicks ignored (R8)
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            kick_man = (i % 3 == 0);
        end
        kick_man = 1'b0;
        chk("R9 request held while power good", int'(pcycle_req), 1);
        chk("R9 reset held during request", int'(sys_rst_n), 0);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R9 request drops after power low", int'(pcycle_req), 0);
        repeat (4) @(negedge clk);
        pwr_good = 1'b1;
        wait_release(n);
        chk("R9 release after power returns", n, HOLDV + 1);

        // R8 window starts at release, earlier kicks left no trace
        wait_req(n);
        chk("R8 window counted from release", n, TOUT);
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        auto_en = 1'b1;
        pwr_good = 1'b1;
        wait_release(n);
        chk("R9 second release", n, HOLDV + 1);

        // R3 drop while running, R4 glitch during hold
        @(negedge clk);
        clk_present = 1'b0;
        @(negedge clk);
        chk("R3 reset after clock loss", int'(sys_rst_n), 0);
        clk_present = 1'b1;
        repeat (3) @(negedge clk);
        clk_present = 1'b0;
        @(negedge clk);
        clk_present = 1'b1;
        wait_release(n);
        chk("R4 hold restarted after glitch", n, HOLDV + 1);

        // R5 minimum pulse with zero hold
        hold_cycles = 16'd0;
        repeat (3) @(negedge clk);
        cfg_ready = 1'b0;
        @(negedge clk);
        cfg_ready = 1'b1;
        lowcnt = sys_rst_n ? 0 : 1;
        forever begin
            @(negedge clk);
            if (sys_rst_n || lowcnt > 100) break;
            lowcnt++;
        end
        chk("R5 minimum pulse width", lowcnt, MINP);
        hold_cycles = 16'(HOLDV);

        // R10 drop and expiry on the same edge
        auto_en = 1'b0;
        repeat (2) @(negedge clk);
        kick_man = 1'b1;
        @(negedge clk);
        kick_man = 1'b0;
        repeat (TOUT - 1) @(negedge clk);
        clk_present = 1'b0;
        @(negedge clk);
        chk("R10 no request on coincident drop", int'(pcycle_req), 0);
        chk("R10 reset asserted", int'(sys_rst_n), 0);
        auto_en = 1'b1;
        clk_present = 1'b1;
        wait_release(n);
        chk("R2 release after coincident drop", n, HOLDV + 1);

        // Random phase with a mimicked sequencer
        auto_en = 1'b0;
        dly = 0; cp_off = 0; quiet = 0;
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            if (pcycle_req && pwr_good) begin
                if (dly == 0) begin
                    pwr_good = 1'b0;
                    dly = 1 + int'($urandom % 6);
                end else dly--;
            end else if (!pwr_good) begin
                if (dly == 0) begin
                    pwr_good = 1'b1;
                    dly = int'($urandom % 8);
                end else dly--;
            end else if ($urandom % 500 == 0) begin
                pwr_good = 1'b0;
                dly = int'($urandom % 4);
            end
            if (cp_off > 0) begin
                cp_off--;
                clk_present = (cp_off == 0);
            end else if ($urandom % 250 == 0) begin
                cp_off = 1 + int'($urandom % 3);
                clk_present = 1'b0;
            end
            cfg_ready = ($urandom % 400 != 0);
            if (quiet > 0) quiet--;
            else if ($urandom % 300 == 0) quiet = 25 + int'($urandom % 20);
            kick_man = (quiet == 0) && ($urandom % 5 == 0);
            if ($urandom % 1000 == 0) hold_cycles = 16'($urandom % 8);
        end
        kick_man = 1'b0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule